// File: doc/BRIEF.md
# Extension Prefix Register Controller

This block sits in the register file of a small 4-bit processor core. It holds an 8-bit extension byte and the 4-bit flag nibble, and one bit of that nibble is the extension-valid flag. A prefix instruction loads the extension byte, which turns the valid flag on. The instruction that follows can then widen its 8-bit operand to 16 bits, using the extension byte as the high half. The flag drops by itself when that following instruction retires, so each load widens exactly one instruction.

The decoder drives single-cycle strobes that coincide with the instruction-retire pulse. The strobes load the extension byte from an immediate or from the BA register pair, write the whole flag nibble, apply an AND, OR or XOR mask to the flags, or restore the nibble from the stack or on return from interrupt. A flag write can raise the valid flag without loading the byte, and the old byte is then reused. The block also tells the interrupt controller to hold off acceptance. The hold covers the instruction after any extension or flag write, so a prefix and the instruction it widens are never split by an interrupt.

Top module: `xpfx_ctrl`

## Requirements
- R1: After a synchronous reset the extension byte reads 0x00, the flag nibble reads 0x0 and the interrupt hold is low.
- R2: When retire is high, an immediate load (ext_ld_imm) stores ext_imm and a pair load (ext_ld_reg) stores ext_ba. In all other cycles the extension byte keeps its value, and it is visible on ext_q one cycle after the retire edge.
- R3: Any extension-byte load sets the valid flag (flag bit 3, also shown on e_flag) to 1.
- R4: When an instruction retires with the valid flag set and writes neither the extension byte nor the flags, the valid flag clears and flag bits 2..0 keep their values.
- R5: A whole-flag write (flg_ld) replaces all four flag bits with flg_arg.
- R6: The mask operations act on the flags bit by bit: flg_and gives flags AND flg_arg, flg_or gives flags OR flg_arg, and flg_xor gives flags XOR flg_arg.
- R7: A restore (flg_rest) replaces the nibble with flg_rest_val. A restored bit 3 of 1 puts the next instruction in extended mode.
- R8: Setting the valid flag through a flag write leaves the extension byte at its previous value.
- R9: An extension or flag write that retires while the valid flag is set takes priority over the automatic clear, so the valid flag takes the value that the write produces.
- R10: irq_hold goes high after the retire of any instruction that writes the extension byte or the flags. It goes low after the next retire that writes neither.
- R11: Strobes that arrive while retire is low change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| retire | input | 1 | Instruction-retire pulse that qualifies all strobes |
| ext_ld_imm | input | 1 | Load the extension byte from the immediate |
| ext_ld_reg | input | 1 | Load the extension byte from the BA pair |
| ext_imm | input | 8 | Immediate byte |
| ext_ba | input | 8 | BA register pair value |
| flg_ld | input | 1 | Write the whole flag nibble from flg_arg |
| flg_and | input | 1 | AND the flags with flg_arg |
| flg_or | input | 1 | OR the flags with flg_arg |
| flg_xor | input | 1 | XOR the flags with flg_arg |
| flg_arg | input | 4 | Operand for the flag write or mask (immediate or A) |
| flg_rest | input | 1 | Restore the flags (pop or interrupt return) |
| flg_rest_val | input | 4 | Nibble restored from the stack |
| ext_q | output | 8 | Extension byte, also the read-back into BA |
| flg_q | output | 4 | Flag nibble for reads and pushes |
| e_flag | output | 1 | Extension-valid flag |
| irq_hold | output | 1 | Interrupt acceptance hold |

## Verification
The checker assumes that the decoder raises at most one flag strobe and at most one extension-load strobe per retire. It also assumes that an extension load and a flag write do not retire together, because the relative order of the two is not defined at the edge. The stimulus task keeps to these rules by issuing one operation per instruction. It then sweeps the mask operations, restores with the valid bit both set and cleared, and back-to-back writes. It also sends strobes with retire low to show that they are ignored.

// File: rtl/xpfx_pkg.sv
package xpfx_pkg;
  localparam int EXT_W_DEF = 8;
  localparam int FLG_W_DEF = 4;
  localparam int E_POS_DEF = 3;

  typedef enum logic [2:0] {
    FOP_NONE = 3'd0,
    FOP_LOAD = 3'd1,
    FOP_AND  = 3'd2,
    FOP_OR   = 3'd3,
    FOP_XOR  = 3'd4
  } flg_op_e;
endpackage

// File: rtl/xpfx_ext_reg.sv
module xpfx_ext_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic         use_pair,
  input  logic [W-1:0] imm,
  input  logic [W-1:0] pair,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else if (we) q <= use_pair ? pair : imm;
  end
endmodule

// File: rtl/xpfx_flag_unit.sv
module xpfx_flag_unit
  import xpfx_pkg::*;
#(
  parameter int W     = 4,
  parameter int E_POS = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         retire,
  input  flg_op_e      op,
  input  logic [W-1:0] opnd,
  input  logic         ext_wr,
  output logic [W-1:0] q
);
  logic [W-1:0] nxt;

  always_comb begin
    nxt = q;
    unique case (op)
      FOP_LOAD: nxt = opnd;
      FOP_AND:  nxt = q & opnd;
      FOP_OR:   nxt = q | opnd;
      FOP_XOR:  nxt = q ^ opnd;
      default:  nxt[E_POS] = 1'b0;
    endcase
    if (ext_wr) nxt[E_POS] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else if (retire) q <= nxt;
  end
endmodule

// File: rtl/xpfx_irq_gate.sv
module xpfx_irq_gate (
  input  logic clk,
  input  logic rst,
  input  logic retire,
  input  logic any_wr,
  output logic hold
);
  always_ff @(posedge clk) begin
    if (rst) hold <= 1'b0;
    else if (retire) hold <= any_wr;
  end
endmodule

// File: rtl/xpfx_ctrl.sv
module xpfx_ctrl
  import xpfx_pkg::*;
#(
  parameter int EXT_W = EXT_W_DEF,
  parameter int FLG_W = FLG_W_DEF,
  parameter int E_POS = E_POS_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             retire,
  input  logic             ext_ld_imm,
  input  logic             ext_ld_reg,
  input  logic [EXT_W-1:0] ext_imm,
  input  logic [EXT_W-1:0] ext_ba,
  input  logic             flg_ld,
  input  logic             flg_and,
  input  logic             flg_or,
  input  logic             flg_xor,
  input  logic [FLG_W-1:0] flg_arg,
  input  logic             flg_rest,
  input  logic [FLG_W-1:0] flg_rest_val,
  output logic [EXT_W-1:0] ext_q,
  output logic [FLG_W-1:0] flg_q,
  output logic             e_flag,
  output logic             irq_hold
);
  logic             ext_wr_rt;
  logic             flg_wr;
  flg_op_e          op;
  logic [FLG_W-1:0] opnd;

  assign ext_wr_rt = retire & (ext_ld_imm | ext_ld_reg);
  assign flg_wr    = flg_rest | flg_ld | flg_and | flg_or | flg_xor;

  // restore outranks the other flag strobes, then load, AND, OR, XOR
  always_comb begin
    op   = FOP_NONE;
    opnd = flg_arg;
    if (flg_rest) begin
      op   = FOP_LOAD;
      opnd = flg_rest_val;
    end else if (flg_ld)  op = FOP_LOAD;
    else if (flg_and)     op = FOP_AND;
    else if (flg_or)      op = FOP_OR;
    else if (flg_xor)     op = FOP_XOR;
  end

  xpfx_ext_reg #(.W(EXT_W)) u_ext (
    .clk(clk), .rst(rst), .we(ext_wr_rt), .use_pair(~ext_ld_imm),
    .imm(ext_imm), .pair(ext_ba), .q(ext_q)
  );

  xpfx_flag_unit #(.W(FLG_W), .E_POS(E_POS)) u_flg (
    .clk(clk), .rst(rst), .retire(retire), .op(op), .opnd(opnd),
    .ext_wr(ext_ld_imm | ext_ld_reg), .q(flg_q)
  );

  xpfx_irq_gate u_gate (
    .clk(clk), .rst(rst), .retire(retire),
    .any_wr(flg_wr | ext_ld_imm | ext_ld_reg), .hold(irq_hold)
  );

  assign e_flag = flg_q[E_POS];
endmodule

// File: rtl/xpfx_ctrl_chk.sv
module xpfx_ctrl_chk #(
  parameter int EXT_W = 8,
  parameter int FLG_W = 4,
  parameter int E_POS = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             retire,
  input logic             ext_ld_imm,
  input logic             ext_ld_reg,
  input logic             flg_ld,
  input logic             flg_and,
  input logic             flg_or,
  input logic             flg_xor,
  input logic             flg_rest,
  input logic [EXT_W-1:0] ext_q,
  input logic [FLG_W-1:0] flg_q,
  input logic             e_flag,
  input logic             irq_hold
);
  logic xw, fw;
  logic [FLG_W-1:0] low_mask;
  assign xw = ext_ld_imm | ext_ld_reg;
  assign fw = flg_ld | flg_and | flg_or | flg_xor | flg_rest;
  always_comb begin
    low_mask = '1;
    low_mask[E_POS] = 1'b0;
  end

  a_r3_ext_sets_e: assert property (@(posedge clk) disable iff (rst)
    retire && xw && !fw |=> e_flag);
  a_r4_auto_clear: assert property (@(posedge clk) disable iff (rst)
    retire && !xw && !fw |=> !e_flag);
  a_r4_low_kept: assert property (@(posedge clk) disable iff (rst)
    retire && !fw |=> (flg_q & low_mask) == $past(flg_q & low_mask));
  a_r2_ext_stable: assert property (@(posedge clk) disable iff (rst)
    !(retire && xw) |=> $stable(ext_q));
  a_r10_hold_set: assert property (@(posedge clk) disable iff (rst)
    retire && (xw || fw) |=> irq_hold);
  a_r10_hold_drop: assert property (@(posedge clk) disable iff (rst)
    retire && !xw && !fw |=> !irq_hold);
  a_r11_idle: assert property (@(posedge clk) disable iff (rst)
    !retire |=> $stable(flg_q) && $stable(irq_hold));
  a_r6_one_op: assert property (@(posedge clk) disable iff (rst)
    retire |-> $onehot0({flg_ld, flg_and, flg_or, flg_xor, flg_rest}));
endmodule

bind xpfx_ctrl xpfx_ctrl_chk #(.EXT_W(EXT_W), .FLG_W(FLG_W), .E_POS(E_POS)) u_chk (
  .clk(clk), .rst(rst), .retire(retire), .ext_ld_imm(ext_ld_imm),
  .ext_ld_reg(ext_ld_reg), .flg_ld(flg_ld), .flg_and(flg_and), .flg_or(flg_or),
  .flg_xor(flg_xor), .flg_rest(flg_rest), .ext_q(ext_q), .flg_q(flg_q),
  .e_flag(e_flag), .irq_hold(irq_hold)
);

// File: tb/xpfx_ctrl_tb.sv
module xpfx_ctrl_tb;
  logic clk = 1'b0, rst = 1'b1, retire = 1'b0;
  logic ext_ld_imm = 0, ext_ld_reg = 0, flg_ld = 0, flg_and = 0, flg_or = 0, flg_xor = 0, flg_rest = 0;
  logic [7:0] ext_imm = 0, ext_ba = 0;
  logic [3:0] flg_arg = 0, flg_rest_val = 0;
  logic [7:0] ext_q;
  logic [3:0] flg_q;
  logic e_flag, irq_hold;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  typedef struct {
    logic [7:0] ext;
    logic [3:0] flg;
    logic       hold;
    int         due;
    string      tag;
  } exp_t;
  exp_t sb[$];

  logic [7:0] m_ext = 0;
  logic [3:0] m_flg = 0;
  logic       m_hold = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  xpfx_ctrl u_dut (
    .clk(clk), .rst(rst), .retire(retire), .ext_ld_imm(ext_ld_imm), .ext_ld_reg(ext_ld_reg),
    .ext_imm(ext_imm), .ext_ba(ext_ba), .flg_ld(flg_ld), .flg_and(flg_and), .flg_or(flg_or),
    .flg_xor(flg_xor), .flg_arg(flg_arg), .flg_rest(flg_rest), .flg_rest_val(flg_rest_val),
    .ext_q(ext_q), .flg_q(flg_q), .e_flag(e_flag), .irq_hold(irq_hold)
  );

  // op: 0 none, 1 imm ext, 2 pair ext, 3 flag load, 4 and, 5 or, 6 xor, 7 restore
  task automatic step(input logic rt, input int op, input logic [7:0] d8,
                      input logic [3:0] d4, input string tag);
    @(negedge clk);
    ext_ld_imm = (op == 1); ext_ld_reg = (op == 2);
    flg_ld = (op == 3); flg_and = (op == 4); flg_or = (op == 5);
    flg_xor = (op == 6); flg_rest = (op == 7);
    ext_imm = (op == 1) ? d8 : ~d8; ext_ba = (op == 2) ? d8 : ~d8;
    flg_arg = d4; flg_rest_val = d4; retire = rt;
    if (rt) begin
      case (op)
        1, 2: begin m_ext = d8; m_flg[3] = 1'b1; end
        3, 7: m_flg = d4;
        4: m_flg = m_flg & d4;
        5: m_flg = m_flg | d4;
        6: m_flg = m_flg ^ d4;
        default: m_flg[3] = 1'b0;
      endcase
      m_hold = (op != 0);
    end
    sb.push_back('{m_ext, m_flg, m_hold, cyc + 1, tag});
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      while (sb.size() > 0 && sb[0].due <= cyc) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (ext_q !== e.ext || flg_q !== e.flg || e_flag !== e.flg[3] || irq_hold !== e.hold) begin
          errors++;
          $display("FAIL %s: got ext=%h flg=%h e=%b hold=%b exp ext=%h flg=%h e=%b hold=%b",
                   e.tag, ext_q, flg_q, e_flag, irq_hold, e.ext, e.flg, e.flg[3], e.hold);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    checks++;
    if (ext_q !== 8'h00 || flg_q !== 4'h0 || irq_hold !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset: ext=%h flg=%h hold=%b exp 00 0 0", ext_q, flg_q, irq_hold);
    end
    rst = 1'b0;
    step(1, 1, 8'h37, 4'h0, "R2 R3 imm load sets E");
    step(1, 0, 8'h00, 4'h0, "R4 E clears after one instr");
    step(1, 2, 8'h5C, 4'h0, "R2 R3 pair load");
    step(1, 0, 8'h00, 4'h0, "R4 R10 clear and hold drop");
    step(1, 3, 8'h00, 4'h7, "R5 whole flag write");
    step(1, 0, 8'h00, 4'h0, "R4 low bits kept");
    step(1, 5, 8'h00, 4'h8, "R6 R8 OR sets E keeps ext");
    step(1, 0, 8'h00, 4'h0, "R4 clear after OR");
    step(1, 4, 8'h00, 4'h5, "R6 AND");
    step(1, 6, 8'h00, 4'h9, "R6 XOR sets E");
    step(1, 2, 8'hA5, 4'h0, "R9 load while E set");
    step(1, 3, 8'h00, 4'h3, "R9 flag write over auto clear");
    step(1, 0, 8'h00, 4'h0, "R10 hold drop");
    step(0, 1, 8'hFF, 4'hF, "R11 imm strobe without retire");
    step(0, 3, 8'h00, 4'hF, "R11 flag strobe without retire");
    step(1, 7, 8'h00, 4'hA, "R7 restore with E");
    step(1, 0, 8'h00, 4'h0, "R7 extended instr then clear");
    step(1, 7, 8'h00, 4'h6, "R7 restore without E");
    step(1, 1, 8'h00, 4'h0, "R2 imm load zero");
    step(1, 0, 8'h00, 4'h0, "R4 final clear");
    step(0, 0, 8'h00, 4'h0, "R11 idle");
    repeat (3) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule